// File: doc/BRIEF.md
# Subclock Interval Timer with Watchdog Tick Source

This block runs a free-running 15-bit counter on a slow subclock. A 3-bit interval code picks one counter bit, and that bit's carry sets a sticky overflow flag. When the interrupt enable is set, the flag raises an interrupt request. Software controls the block through one 8-bit control register. It can zero the counter, clear the flag, pick the interval and choose where the watchdog's tick comes from.

After reset, a separate counter times a fixed stabilization wait of 2^14 subclock cycles for the subclock oscillator. A read-only status bit reports the end of that wait. A source select steers a tick to the `wdog_tick` output. That tick is either this block's own selected carry or an external timebase pulse.

The asynchronous reset input passes through a two-stage synchronizer. The internal logic therefore leaves reset at the second clock edge after `rst_n` rises. Software should clear the overflow flag before it changes the interval code. The block does not enforce this rule.

Top module: `watch_timer`

## Requirements
- R1: After reset, `rd_data` reads 8'h08. The bit positions are: bit 7 watchdog source select, bit 6 stabilization-done status, bit 5 interrupt enable, bit 4 overflow flag, bit 3 counter clear (always reads 1), bits 2..0 interval code. `irq` and `wdog_tick` are 0.
- R2: Interval code n (0..7) selects the carry of counter bit 7+n. A write that zeroes the counter at edge E makes the flag read 1 after edge E+2^(8+n) and not before.
- R3: `irq` equals the overflow flag ANDed with the interrupt enable. With the enable at 0 the flag still sets, but `irq` stays 0.
- R4: Writing 0 to bit 3 zeroes the counter at that edge, and no carry is taken in that cycle. Writing 1 to bit 3 leaves the counter running. Bit 3 always reads 1.
- R5: Writing 0 to bit 4 clears the flag. Writing 1 to bit 4 leaves the flag unchanged. A carry in the same cycle as a clearing write wins, and the flag stays 1.
- R6: `wdog_tick` is registered. With bit 7 at 1 it repeats `tb_tick` one cycle later. With bit 7 at 0 it repeats the selected counter carry one cycle later, and `tb_tick` is ignored.
- R7: Bit 6 reads 0 until 2^14 edges have passed since the internal reset release, so it first reads 1 after the 16386th edge following the rise of `rst_n`. It then stays 1 until the next reset.
- R8: Bits 7, 5 and 2..0 read back the last written values. Writes to bit 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subclock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| tb_tick | input | 1 | Timebase tick, single-cycle pulse, already synchronous to `clk` |
| rd_data | output | 8 | Control register read value |
| irq | output | 1 | Overflow interrupt request |
| wdog_tick | output | 1 | Tick pulse for the watchdog |

## Verification
Two events can land on the same edge: a software write that clears the overflow flag, and the carry of the selected counter bit that sets it. The bench first zeroes the counter with interval code 0, so the next carry falls exactly 256 edges later. It then times a flag-clearing write to hit that edge. The flag must still read 1 afterwards. A related case is also covered: a counter-clear write that falls while the carry is pending must push the flag's rise back by a full interval.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CTRL_W   = 8;
  localparam int SEL_W    = 3;
  localparam int B_WDSEL  = 7;
  localparam int B_STAB   = 6;
  localparam int B_IE     = 5;
  localparam int B_FLAG   = 4;
  localparam int B_CLR    = 3;

  typedef struct packed {
    logic             wdsel;
    logic             ie;
    logic             flag;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/wt_rst_sync.sv
module wt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_int_n = s2_q;
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W    = 15,
  parameter int SEL_W    = 3,
  parameter int TAP_BASE = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             tap_carry
);
  localparam int NTAP = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NTAP-1:0]  carry_vec;

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign carry_vec[i] = &cnt_q[TAP_BASE+i:0];
    end
  endgenerate

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tap_carry = ~clr & carry_vec[sel];
  assign count     = cnt_q;
endmodule

// File: rtl/wt_stab.sv
module wt_stab #(
  parameter int STAB_LOG2 = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam logic [STAB_LOG2-1:0] LAST = '1;

  logic [STAB_LOG2-1:0] cnt_q, cnt_d;
  logic                 done_q, done_d;
  logic                 en;

  assign en = ~done_q;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    done_d = (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              tap_carry,
  input  logic              tb_tick,
  input  logic              stab_done,
  output logic [SEL_W-1:0]  sel,
  output logic              cnt_clr,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq,
  output logic              wdog_tick
);
  ctrl_t ctrl_q, ctrl_d;
  logic  wdog_q, wdog_d;
  logic  unused_wbits;

  assign unused_wbits = wr_data[B_STAB];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.wdsel = wr_data[B_WDSEL];
      ctrl_d.ie    = wr_data[B_IE];
      ctrl_d.sel   = wr_data[SEL_W-1:0];
      if (!wr_data[B_FLAG]) ctrl_d.flag = 1'b0;
    end
    if (tap_carry) ctrl_d.flag = 1'b1;
    wdog_d = ctrl_q.wdsel ? tb_tick : tap_carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wdog_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      wdog_q <= wdog_d;
    end
  end

  assign cnt_clr   = wr_en & ~wr_data[B_CLR];
  assign sel       = ctrl_q.sel;
  assign irq       = ctrl_q.flag & ctrl_q.ie;
  assign wdog_tick = wdog_q;
  assign rd_data   = {ctrl_q.wdsel, stab_done, ctrl_q.ie, ctrl_q.flag, 1'b1, ctrl_q.sel};
endmodule

// File: rtl/watch_timer.sv
module watch_timer #(
  parameter int CNT_W     = 15,
  parameter int TAP_BASE  = 7,
  parameter int STAB_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tb_tick,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       wdog_tick
);
  import wt_pkg::*;

  logic             rst_int_n;
  logic [SEL_W-1:0] sel;
  logic             cnt_clr;
  logic             tap_carry;
  logic [CNT_W-1:0] count_q;
  logic             stab_done;
  logic             unused_cnt;

  assign unused_cnt = ^count_q;

  wt_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  wt_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .TAP_BASE(TAP_BASE)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (cnt_clr),
    .sel       (sel),
    .count     (count_q),
    .tap_carry (tap_carry)
  );

  wt_stab #(.STAB_LOG2(STAB_LOG2)) u_stab (
    .clk   (clk),
    .rst_n (rst_int_n),
    .done  (stab_done)
  );

  wt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tap_carry (tap_carry),
    .tb_tick   (tb_tick),
    .stab_done (stab_done),
    .sel       (sel),
    .cnt_clr   (cnt_clr),
    .rd_data   (rd_data),
    .irq       (irq),
    .wdog_tick (wdog_tick)
  );
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             tb_tick,
  input logic [7:0]       rd_data,
  input logic             irq,
  input logic             wdog_tick,
  input logic             tap_carry,
  input logic [CNT_W-1:0] count
);
  assert_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[4] & rd_data[5]));

  assert_clrbit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3]);

  assert_cntclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3]) |=> (count == '0));

  assert_flagset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tap_carry |=> rd_data[4]);

  assert_flagclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[4] && !tap_carry) |=> !rd_data[4]);

  assert_wdtb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && tb_tick) |=> wdog_tick);

  assert_wdquiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[7] && !tap_carry) |=> !wdog_tick);

  assert_stab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] |=> rd_data[6]);
endmodule

bind watch_timer wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .tb_tick   (tb_tick),
  .rd_data   (rd_data),
  .irq       (irq),
  .wdog_tick (wdog_tick),
  .tap_carry (tap_carry),
  .count     (count_q)
);

// File: tb/watch_timer_tb.sv
module watch_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       tb_tick;
  logic [7:0] rd_data;
  logic       irq;
  logic       wdog_tick;

  int n_checks;
  int n_fail;

  watch_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tb_tick   (tb_tick),
    .rd_data   (rd_data),
    .irq       (irq),
    .wdog_tick (wdog_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] cw(input logic wd, input logic ie, input logic fl,
                                    input logic clr, input logic [2:0] s);
    return {wd, 1'b0, ie, fl, clr, s};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge, returns at the following negedge
  task automatic wr(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic t_reset_and_stab();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tb_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h08);
    chk("R1 irq", irq, 0);
    chk("R1 wdog_tick", wdog_tick, 0);
    repeat (16384) @(negedge clk);
    chk("R7 stab before end", rd_data[6], 0);
    @(negedge clk);
    chk("R7 stab at end", rd_data[6], 1);
  endtask

  task automatic t_interval(input int code);
    int p;
    p = 1 << (8 + code);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b0, code[2:0]));
    repeat (p - 1) @(negedge clk);
    chk($sformatf("R2 code %0d flag early", code), rd_data[4], 0);
    @(negedge clk);
    chk($sformatf("R2 code %0d flag set", code), rd_data[4], 1);
    chk("R3 irq with enable", irq, 1);
    chk("R8 interval readback", rd_data[2:0], code);
    chk("R8 enable readback", rd_data[5], 1);
  endtask

  task automatic t_irq_off();
    wr(cw(1'b0, 1'b0, 1'b0, 1'b0, 3'd0));
    repeat (256) @(negedge clk);
    chk("R3 flag sets with enable off", rd_data[4], 1);
    chk("R3 irq held low", irq, 0);
    wr(cw(1'b0, 1'b1, 1'b1, 1'b1, 3'd0));
    chk("R5 write 1 keeps flag", rd_data[4], 1);
    chk("R3 irq after enable", irq, 1);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b1, 3'd0) | 8'h40);
    chk("R5 write 0 clears flag", rd_data[4], 0);
    chk("R3 irq drops with flag", irq, 0);
    chk("R8 stab bit read-only", rd_data[6], 1);
  endtask

  task automatic t_collision();
    wr(cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    repeat (255) @(negedge clk);
    chk("R5 flag low before carry", rd_data[4], 0);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b1, 3'd0));
    chk("R5 carry beats clearing write", rd_data[4], 1);
  endtask

  task automatic t_clrbit();
    wr(cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    repeat (99) @(negedge clk);
    wr(cw(1'b0, 1'b1, 1'b1, 1'b1, 3'd0));
    chk("R4 clear bit reads 1", rd_data[3], 1);
    repeat (155) @(negedge clk);
    chk("R4 write 1 no effect, early", rd_data[4], 0);
    @(negedge clk);
    chk("R4 write 1 no effect, carry", rd_data[4], 1);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    repeat (200) @(negedge clk);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    repeat (255) @(negedge clk);
    chk("R4 clear restarts interval", rd_data[4], 0);
    @(negedge clk);
    chk("R4 carry after restart", rd_data[4], 1);
  endtask

  task automatic t_wdog();
    wr(cw(1'b1, 1'b1, 1'b0, 1'b0, 3'd0));
    chk("R8 source select readback", rd_data[7], 1);
    repeat (10) @(negedge clk);
    tb_tick = 1'b1;
    @(negedge clk);
    tb_tick = 1'b0;
    chk("R6 timebase tick passes", wdog_tick, 1);
    @(negedge clk);
    chk("R6 tick one cycle", wdog_tick, 0);
    repeat (244) @(negedge clk);
    chk("R6 carry blocked when timebase chosen", wdog_tick, 0);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    repeat (10) @(negedge clk);
    tb_tick = 1'b1;
    @(negedge clk);
    tb_tick = 1'b0;
    chk("R6 timebase ignored", wdog_tick, 0);
    repeat (245) @(negedge clk);
    chk("R6 carry tick", wdog_tick, 1);
    @(negedge clk);
    chk("R6 carry tick one cycle", wdog_tick, 0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    t_reset_and_stab();
    t_interval(0);
    t_interval(3);
    t_interval(7);
    t_irq_off();
    t_collision();
    t_clrbit();
    t_wdog();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule